// File: doc/BRIEF.md
# Link Power State Wake Controller

This block follows the power state of one serial storage link on the host side. The link is in one of three states: Ready, Partial or Slumber. The device may ask to move the idle link into Partial or Slumber. The host side answers every such request with an acknowledge, but it never starts a low-power entry of its own.

When the host transport layer wants to send while the link is in a low-power state, the block holds the request with the grant low. It pulses a wake command toward the PHY and waits for the PHY to report that the link is ready. Only then does it grant the request. The device may also wake the link, which returns the block to Ready.

A programmable wake timeout guards the wait. If link-ready does not arrive in time, the block falls back to Ready and raises an error flag.

Top module: `lpw_link_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 0 (Ready) and `pm_ack`, `tx_grant`, `wake_send` and `wake_err` are all low.
- R2: A device request (`dev_pm_req` high) taken in Ready with `tx_req` low moves `pwr_state` one cycle later to 1 (Partial, `dev_pm_deep`=0) or to 2 (Slumber, `dev_pm_deep`=1).
- R3: Every cycle with `dev_pm_req` high is followed in the next cycle by a one-cycle `pm_ack`, whatever the state.
- R4: A device request that arrives in Ready in the same cycle as `tx_req` is acknowledged. The link stays in Ready and the host request is granted.
- R5: In Ready, a high `tx_req` gives `tx_grant` high in the next cycle for exactly one cycle.
- R6: A `tx_req` seen in Partial or Slumber gives a one-cycle `wake_send` in the next cycle, with `pwr_state`=3 (waking). `tx_grant` stays low until `phy_ready` is seen. The state is then Ready one cycle later, and the grant follows in the cycle after that.
- R7: A `dev_wake` seen in Partial, Slumber or waking returns `pwr_state` to 0 in the next cycle, and no `wake_send` is produced for it.
- R8: If `phy_ready` has not arrived by the `wake_limit`-th cycle spent waking, the block returns to Ready and sets `wake_err`. `wake_err` stays set until the next `wake_send`, which clears it.
- R9: A device request taken in Partial, Slumber or waking is acknowledged and leaves `pwr_state` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_limit | input | CNT_W | Number of waking cycles allowed before timeout |
| dev_pm_req | input | 1 | Decoded device low-power request, one cycle per request |
| dev_pm_deep | input | 1 | Requested depth: 0 Partial, 1 Slumber |
| dev_wake | input | 1 | Device-side wake detected |
| tx_req | input | 1 | Host transport request to send, held until granted |
| phy_ready | input | 1 | PHY reports the link ready |
| pm_ack | output | 1 | Acknowledge for a device power request |
| tx_grant | output | 1 | One-cycle grant of the host request |
| wake_send | output | 1 | One-cycle command to the PHY to send a wake |
| wake_err | output | 1 | Wake timeout flag |
| pwr_state | output | 2 | 0 Ready, 1 Partial, 2 Slumber, 3 waking |

## Verification
All results come from one register stage, so each output is due one cycle after the input edge that caused it. The acknowledge, the state change, the wake pulse and the ready grant each appear one cycle after their stimulus. A grant after a wake comes two cycles after `phy_ready`, and a timeout comes exactly `wake_limit` cycles after the wake pulse. The bench drives inputs and samples outputs on the falling edge. On every falling edge it compares all five outputs against a behavioural model that advances on the rising edge. Directed checks after each scenario name the requirement they cover.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [1:0] {
    ST_READY   = 2'd0,
    ST_PARTIAL = 2'd1,
    ST_SLUMBER = 2'd2,
    ST_WAKING  = 2'd3
  } lpw_state_e;

  // True once the cycle now ending is the limit-th one spent waking.
  function automatic logic limit_hit(input logic [31:0] cnt, input logic [31:0] limit);
    return (cnt + 32'd1) >= limit;
  endfunction

  function automatic lpw_state_e depth_to_state(input logic deep);
    return deep ? ST_SLUMBER : ST_PARTIAL;
  endfunction

  function automatic logic is_low_power(input lpw_state_e st);
    return (st == ST_PARTIAL) || (st == ST_SLUMBER);
  endfunction

endpackage

// File: rtl/lpw_ack.sv
module lpw_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ack
);

  always_ff @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= req;
  end

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack);  // R3

  AST_ACK_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !ack);  // R3

endmodule

// File: rtl/lpw_wake_timer.sv
module lpw_wake_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             phy_ready,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  import lpw_pkg::*;

  localparam int PADW = 32 - CNT_W;

  logic [CNT_W-1:0] cnt;
  logic [31:0]      cnt_wide;
  logic [31:0]      lim_wide;

  assign cnt_wide = {{PADW{1'b0}}, cnt};
  assign lim_wide = {{PADW{1'b0}}, limit};
  assign expire   = run && !phy_ready && limit_hit(cnt_wide, lim_wide);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  AST_CNT_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));  // R8

endmodule

// File: rtl/lpw_fsm.sv
module lpw_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_pm_req,
  input  logic              dev_pm_deep,
  input  logic              dev_wake,
  input  logic              tx_req,
  input  logic              phy_ready,
  input  logic              expire,
  output lpw_pkg::lpw_state_e st,
  output logic              tx_grant,
  output logic              wake_send,
  output logic              wake_err
);
  import lpw_pkg::*;

  lpw_state_e st_nx;
  logic       grant_nx;
  logic       wake_nx;
  logic       err_set;
  logic       lp_accept;
  logic       ready_grant;

  assign lp_accept   = (st == ST_READY) && dev_pm_req && !tx_req;
  assign ready_grant = (st == ST_READY) && tx_req && !tx_grant;

  always_comb begin
    st_nx    = st;
    grant_nx = ready_grant;
    wake_nx  = 1'b0;
    err_set  = 1'b0;
    unique case (st)
      ST_READY: begin
        if (lp_accept) st_nx = depth_to_state(dev_pm_deep);
      end
      ST_PARTIAL, ST_SLUMBER: begin
        if (dev_wake) begin
          st_nx = ST_READY;
        end else if (tx_req) begin
          st_nx   = ST_WAKING;
          wake_nx = 1'b1;
        end
      end
      ST_WAKING: begin
        if (dev_wake || phy_ready) begin
          st_nx = ST_READY;
        end else if (expire) begin
          st_nx   = ST_READY;
          err_set = 1'b1;
        end
      end
      default: st_nx = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_READY;
      tx_grant  <= 1'b0;
      wake_send <= 1'b0;
      wake_err  <= 1'b0;
    end else begin
      st        <= st_nx;
      tx_grant  <= grant_nx;
      wake_send <= wake_nx;
      if (err_set)      wake_err <= 1'b1;
      else if (wake_nx) wake_err <= 1'b0;
    end
  end

  AST_LP_ONLY_BY_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_READY) && !dev_pm_req) |=> (st == ST_READY || st == ST_WAKING) && (st != ST_WAKING));  // R2

  AST_HOST_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_READY) && tx_req) |=> (st == ST_READY));  // R4

  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> !tx_grant);  // R5

  AST_GRANT_IN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> (st == ST_READY));  // R6

  AST_WAKE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wake_send |-> ($past(st) == ST_PARTIAL || $past(st) == ST_SLUMBER));  // R6

  AST_WAKING_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_send |-> (st == ST_WAKING));  // R6

  AST_DEV_WAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wake && st != ST_READY) |=> (st == ST_READY) && !wake_send);  // R7

  AST_ERR_IN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_err) |-> (st == ST_READY) && ($past(st) == ST_WAKING));  // R8

  AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_low_power(st) && !dev_wake && !tx_req) |=> $stable(st));  // R9

endmodule

// File: rtl/lpw_link_ctrl.sv
module lpw_link_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] wake_limit,
  input  logic             dev_pm_req,
  input  logic             dev_pm_deep,
  input  logic             dev_wake,
  input  logic             tx_req,
  input  logic             phy_ready,
  output logic             pm_ack,
  output logic             tx_grant,
  output logic             wake_send,
  output logic             wake_err,
  output logic [1:0]       pwr_state
);
  import lpw_pkg::*;

  lpw_state_e st;
  logic       timer_run;
  logic       timer_expire;

  assign timer_run = (st == ST_WAKING);
  assign pwr_state = st;

  lpw_ack u_ack (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (dev_pm_req),
    .ack   (pm_ack)
  );

  lpw_wake_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (timer_run),
    .phy_ready (phy_ready),
    .limit     (wake_limit),
    .expire    (timer_expire)
  );

  lpw_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_pm_req  (dev_pm_req),
    .dev_pm_deep (dev_pm_deep),
    .dev_wake    (dev_wake),
    .tx_req      (tx_req),
    .phy_ready   (phy_ready),
    .expire      (timer_expire),
    .st          (st),
    .tx_grant    (tx_grant),
    .wake_send   (wake_send),
    .wake_err    (wake_err)
  );

  AST_EXPIRE_ONLY_WAKING: assert property (@(posedge clk) disable iff (!rst_n)
    timer_expire |-> (pwr_state == 2'd3));  // R8

endmodule

// File: tb/lpw_link_ctrl_test.sv
module lpw_link_ctrl_test;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] wake_limit = 16'd20;
  logic          dev_pm_req = 1'b0, dev_pm_deep = 1'b0, dev_wake = 1'b0;
  logic          tx_req = 1'b0, phy_ready = 1'b0;
  logic          pm_ack, tx_grant, wake_send, wake_err;
  logic [1:0]    pwr_state;

  int total = 0, bad = 0;
  bit done = 0;
  int phy_delay = 3;
  int phy_cd = 0;

  // behavioural reference
  int m_st = 0, m_cnt = 0;
  bit m_ack = 0, m_grant = 0, m_ws = 0, m_err = 0;

  always #4 clk = ~clk;

  lpw_link_ctrl #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wake_limit(wake_limit),
    .dev_pm_req(dev_pm_req), .dev_pm_deep(dev_pm_deep), .dev_wake(dev_wake),
    .tx_req(tx_req), .phy_ready(phy_ready),
    .pm_ack(pm_ack), .tx_grant(tx_grant), .wake_send(wake_send),
    .wake_err(wake_err), .pwr_state(pwr_state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int ns;
    bit ng, nw, ne;
    if (!rst_n) begin
      m_st = 0; m_ack = 0; m_grant = 0; m_ws = 0; m_err = 0; m_cnt = 0;
    end else begin
      ns = m_st; ng = 0; nw = 0; ne = m_err;
      if (m_st == 0) begin
        if (tx_req) ng = !m_grant;
        else if (dev_pm_req) ns = dev_pm_deep ? 2 : 1;
      end else if (m_st == 1 || m_st == 2) begin
        if (dev_wake) ns = 0;
        else if (tx_req) begin ns = 3; nw = 1; ne = 0; m_cnt = 0; end
      end else begin
        if (dev_wake || phy_ready) ns = 0;
        else begin
          m_cnt++;
          if (m_cnt >= int'(wake_limit)) begin ns = 0; ne = 1; end
        end
      end
      m_ack = dev_pm_req; m_st = ns; m_grant = ng; m_ws = nw; m_err = ne;
    end
  end

  // PHY responder and per-cycle comparison
  always @(negedge clk) begin
    phy_ready <= 1'b0;
    if (wake_send && phy_delay >= 0) phy_cd = phy_delay;
    else if (phy_cd > 0) begin
      phy_cd--;
      if (phy_cd == 0) phy_ready <= 1'b1;
    end
    if (rst_n && !done) begin
      chk(pm_ack == m_ack, "R3 ack", int'(pm_ack), int'(m_ack));
      chk(tx_grant == m_grant, "R5 grant", int'(tx_grant), int'(m_grant));
      chk(wake_send == m_ws, "R6 wake_send", int'(wake_send), int'(m_ws));
      chk(wake_err == m_err, "R8 wake_err", int'(wake_err), int'(m_err));
      chk(int'(pwr_state) == m_st, "R2 state", int'(pwr_state), m_st);
    end
  end

  task automatic dev_request(input bit deep);
    dev_pm_req = 1'b1; dev_pm_deep = deep;
    @(negedge clk);
    dev_pm_req = 1'b0;
  endtask

  task automatic host_send();
    tx_req = 1'b1;
    do @(negedge clk); while (!tx_grant);
    tx_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk(pwr_state == 2'd0 && !pm_ack && !tx_grant && !wake_send && !wake_err,
        "R1 reset", int'(pwr_state), 0);
    rst_n = 1'b1;
    idle(2);

    host_send();                      // R5 grant in Ready
    chk(pwr_state == 2'd0, "R5 ready kept", int'(pwr_state), 0);
    idle(2);

    dev_request(1'b0);
    chk(pwr_state == 2'd1, "R2 partial", int'(pwr_state), 1);
    dev_request(1'b1);                // ignored in Partial
    chk(pwr_state == 2'd1 && pm_ack, "R9 req in partial", int'(pwr_state), 1);
    idle(2);

    phy_delay = 3;
    tx_req = 1'b1;
    @(negedge clk);
    chk(wake_send && pwr_state == 2'd3, "R6 wake pulse", int'(pwr_state), 3);
    do @(negedge clk); while (!tx_grant);
    tx_req = 1'b0;
    chk(pwr_state == 2'd0, "R6 ready after wake", int'(pwr_state), 0);
    idle(2);

    dev_request(1'b1);
    chk(pwr_state == 2'd2, "R2 slumber", int'(pwr_state), 2);
    dev_wake = 1'b1; @(negedge clk); dev_wake = 1'b0;
    chk(pwr_state == 2'd0 && !wake_send, "R7 device wake", int'(pwr_state), 0);
    idle(2);

    dev_pm_req = 1'b1; dev_pm_deep = 1'b1; tx_req = 1'b1;
    @(negedge clk);
    dev_pm_req = 1'b0;
    chk(pm_ack && tx_grant && pwr_state == 2'd0, "R4 host wins", int'(pwr_state), 0);
    tx_req = 1'b0;
    idle(2);

    wake_limit = 16'd5; phy_delay = -1;
    dev_request(1'b1);
    tx_req = 1'b1;
    @(negedge clk);
    chk(wake_send == 1'b1, "R6 wake for timeout", int'(wake_send), 1);
    idle(4);
    chk(pwr_state == 2'd3 && !wake_err, "R8 still waking", int'(pwr_state), 3);
    @(negedge clk);
    chk(pwr_state == 2'd0 && wake_err, "R8 timeout", int'(wake_err), 1);
    do @(negedge clk); while (!tx_grant);
    tx_req = 1'b0;
    idle(2);

    phy_delay = 2;
    dev_request(1'b0);
    chk(wake_err == 1'b1, "R8 err held", int'(wake_err), 1);
    tx_req = 1'b1;
    @(negedge clk);
    chk(!wake_err && wake_send, "R8 err cleared", int'(wake_err), 0);
    do @(negedge clk); while (!tx_grant);
    tx_req = 1'b0;
    idle(2);

    wake_limit = 16'd50; phy_delay = -1;
    dev_request(1'b0);
    tx_req = 1'b1;
    idle(3);
    dev_request(1'b1);                // ignored while waking
    chk(pwr_state == 2'd3 && pm_ack, "R9 req while waking", int'(pwr_state), 3);
    dev_wake = 1'b1; @(negedge clk); dev_wake = 1'b0;
    chk(pwr_state == 2'd0 && !wake_err, "R7 wake during waking", int'(pwr_state), 0);
    do @(negedge clk); while (!tx_grant);
    tx_req = 1'b0;
    idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule